// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block is a controller that takes a PCIe root port from reset to a trained link. A start pulse begins the sequence. The sequencer asserts the controller reset lines in two groups and holds them for a settle time. It then releases the bus-side resets, programs the mode straps, switches on the lane PHYs one at a time, and releases the core-side resets in a fixed order. Finally it drives the endpoint reset pin (PERST) high and waits before it enables link training.

Once training is enabled, the block samples the link-state field on every millisecond tick. If the link stays down, the target generation is lowered and the whole reset sequence runs again. A Gen2 target also needs a retrain request followed by a check that the link reached 5 GT/s. After a final settle wait, the block raises either done or fail. A running count of the milliseconds spent waiting is kept on an output, so that a system can add any further delay it needs. The millisecond tick comes from an external prescaler, and the link partner lives outside the block.

Top module: `rp_bringup_seq`

## Requirements
- R1: After reset, these are the output values:
  - `rst_o` = 7'h7F, with every reset asserted.
  - `perst_n_o` = 0.
  - `phy_en_o` = 0.
  - `strap_wr_o` = 0, `retrain_o` = 0, `done_o` = 0, `fail_o` = 0, `gen_o` = 0, `waited_ms_o` = 0.
- R2: Every strap write is one 32-bit word. Bits [31:16] are per-bit write enables for the data bits [15:0]. Bit 7 = 1 selects Gen2. Bit 6 = 1 selects root port. Bits 5:4 carry log2 of the lane count (`lanes_i` 1, 2 or 4 gives 0, 1 or 2). Bit 1 starts training. Bit 0 enables configuration. Each attempt makes three writes, in this order:
  - the speed word, 0x00800080 for Gen2 or 0x00800000 for Gen1;
  - the mode word, 0x00710041 | (code << 4);
  - the training word, 0x00020002.
- R3: `rst_o` bit map: [0] AXI clock, [1] APB clock, [2] power management, [3] core, [4] management, [5] sticky management, [6] pipe. The assert phase spans two cycles:
  - first cycle: PERST goes low and bits 2:0 are set;
  - next cycle: bits 6:3 are set and all PHY enables are cleared.
- R4: After the hold of HOLD_MS ticks (default 1), bits 2:0 are released together. This happens before the first strap write of the attempt.
- R5: The PHYs are enabled after the mode word, one per cycle, walking down from lane 3 to lane 0. Only lanes below the lane count are switched on.
- R6: The core-side resets are released one per cycle in this order: sticky management, core, management, pipe. PERST goes high in the next cycle. The training word follows after PERST_MS ticks (default 20).
- R7: `link_st_i` is sampled on each tick and only the value 3 counts as success. After POLL_LIMIT ticks (default 500) with no success:
  - a Gen2 target drops to Gen1 and the sequence restarts from the assert phase;
  - a Gen1 target sets `fail_o`.
- R8: With a Gen2 target, a successful link is followed by a one-cycle `retrain_o` pulse. The block then samples `(cur_speed_i & 8'h18) == 8'h08` on each tick. If this has not held after POLL_LIMIT ticks, the target falls to Gen1 and the sequence restarts.
- R9: After success, SETTLE_MS ticks (default 80) pass before `done_o` rises. `done_o` is never high together with `fail_o`. `done_o` and `fail_o` hold until the next accepted start. `gen_o` reports the generation reached (1 or 2).
- R10: `max_gen_i` values 0 and 1 give a Gen1 target. Values 2 and 3 give a Gen2 target.
- R11: A start pulse is accepted only when the block is idle, done or failed. A start pulse while the sequence is running has no effect.
- R12: `waited_ms_o` counts every tick seen during the hold, PERST, poll and settle waits. It is cleared by an accepted start and holds its value once the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| max_gen_i | input | 2 | Highest generation allowed |
| lanes_i | input | 3 | Lane count: 1, 2 or 4 |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| link_st_i | input | 2 | Link-state field |
| cur_speed_i | input | 8 | Current-speed field |
| rst_o | output | 7 | Controller reset lines, active high |
| perst_n_o | output | 1 | Endpoint reset pin, active low |
| strap_wr_o | output | 1 | Strap write strobe |
| strap_data_o | output | 32 | Strap word, enables in the upper half |
| phy_en_o | output | 4 | Per-lane PHY enables |
| retrain_o | output | 1 | Retrain request pulse |
| done_o | output | 1 | Link trained and settled |
| fail_o | output | 1 | Training failed at Gen1 |
| gen_o | output | 2 | Target or reached generation |
| waited_ms_o | output | 16 | Milliseconds spent waiting |

## Verification
A wrong state or a wrong lane index shows up at once as a strap word, reset edge or PHY enable that is missing, extra or out of order. The bench compares every one of these edges, in the cycle it occurs, against an expected event queue. A wait counter that is off by even one tick can shift the timing of its own edges and still go unseen by the queue. It does show up at the end of the run, as a `waited_ms_o` total that differs from the sum the requirements predict. A broken fallback path shows up as a wrong `gen_o`, a missing second pass of the reset sequence, or `fail_o` in place of `done_o`.

// File: rtl/rp_bringup_pkg.sv
package rp_bringup_pkg;

    localparam int NPHY  = 4;
    localparam int NRST  = 7;
    localparam int IDX_W = $clog2(NPHY);

    // reset line positions in rst_o
    localparam int RB_ACLK   = 0;
    localparam int RB_PCLK   = 1;
    localparam int RB_PM     = 2;
    localparam int RB_CORE   = 3;
    localparam int RB_MGMT   = 4;
    localparam int RB_STICKY = 5;
    localparam int RB_PIPE   = 6;

    typedef enum logic [4:0] {
        S_IDLE, S_ASSERT_BUS, S_ASSERT_CORE, S_HOLD, S_REL_BUS,
        S_STRAP_SPD, S_STRAP_MODE, S_PHY_ON, S_REL_CORE, S_PERST_HI,
        S_WAIT_PERST, S_STRAP_TRAIN, S_POLL_LINK, S_RETRAIN, S_POLL_SPD,
        S_SETTLE, S_DONE, S_FAIL
    } state_e;

    typedef enum logic [1:0] {
        STRAP_SPEED, STRAP_MODE, STRAP_TRAIN
    } strap_e;

    typedef struct packed {
        state_e            st;
        logic [1:0]        gen;
        logic [1:0]        lc;
        logic [IDX_W-1:0]  idx;
        logic [NRST-1:0]   rst;
        logic              perst_n;
        logic [NPHY-1:0]   phy;
        logic              done;
        logic              fail;
    } ctl_t;

endpackage

// File: rtl/rp_tick_counter.sv
module rp_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rp_strap_fmt.sv
module rp_strap_fmt
    import rp_bringup_pkg::*;
(
    input  strap_e      kind_i,
    input  logic        gen2_i,
    input  logic [1:0]  lc_i,
    output logic [31:0] word_o
);
    localparam int B_GEN   = 7;
    localparam int B_ROOT  = 6;
    localparam int B_LC    = 4;
    localparam int B_TRAIN = 1;
    localparam int B_CFG   = 0;

    logic [15:0] en, val;

    always_comb begin
        en  = '0;
        val = '0;
        case (kind_i)
            STRAP_SPEED: begin
                en[B_GEN]  = 1'b1;
                val[B_GEN] = gen2_i;
            end
            STRAP_MODE: begin
                en[B_ROOT]     = 1'b1;
                en[B_LC +: 2]  = 2'b11;
                en[B_CFG]      = 1'b1;
                val[B_ROOT]    = 1'b1;
                val[B_LC +: 2] = lc_i;
                val[B_CFG]     = 1'b1;
            end
            default: begin
                en[B_TRAIN]  = 1'b1;
                val[B_TRAIN] = 1'b1;
            end
        endcase
        word_o = {en, val};
    end
endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
    import rp_bringup_pkg::*;
#(
    parameter int HOLD_MS    = 1,
    parameter int PERST_MS   = 20,
    parameter int POLL_LIMIT = 500,
    parameter int SETTLE_MS  = 80,
    parameter int WAIT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         max_gen_i,
    input  logic [2:0]         lanes_i,
    input  logic               ms_tick_i,
    input  logic [1:0]         link_st_i,
    input  logic [7:0]         cur_speed_i,
    output logic [NRST-1:0]    rst_o,
    output logic               perst_n_o,
    output logic               strap_wr_o,
    output logic [31:0]        strap_data_o,
    output logic [NPHY-1:0]    phy_en_o,
    output logic               retrain_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [1:0]         gen_o,
    output logic [WAIT_W-1:0]  waited_ms_o
);
    localparam int CNT_W = $clog2(HOLD_MS + PERST_MS + POLL_LIMIT + SETTLE_MS + 1);
    localparam logic [CNT_W-1:0] LIM_HOLD   = CNT_W'(HOLD_MS - 1);
    localparam logic [CNT_W-1:0] LIM_PERST  = CNT_W'(PERST_MS - 1);
    localparam logic [CNT_W-1:0] LIM_POLL   = CNT_W'(POLL_LIMIT - 1);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_MS - 1);
    localparam logic [7:0] SPD_MASK = 8'h18;
    localparam logic [7:0] SPD_5GT  = 8'h08;
    localparam logic [1:0] LINK_UP  = 2'd3;

    ctl_t q, n;
    logic [CNT_W-1:0] wcnt;
    logic             waiting, wclr, run_clr;
    strap_e           strap_kind;

    assign waiting = (q.st == S_HOLD) || (q.st == S_WAIT_PERST) || (q.st == S_POLL_LINK)
                  || (q.st == S_POLL_SPD) || (q.st == S_SETTLE);

    // next-state and output register computation
    always_comb begin
        n       = q;
        run_clr = 1'b0;
        case (q.st)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start_i) begin
                    n.st    = S_ASSERT_BUS;
                    n.gen   = max_gen_i[1] ? 2'd2 : 2'd1;
                    n.lc    = (lanes_i == 3'd4) ? 2'd2 : (lanes_i == 3'd2) ? 2'd1 : 2'd0;
                    n.done  = 1'b0;
                    n.fail  = 1'b0;
                    run_clr = 1'b1;
                end
            end
            S_ASSERT_BUS: begin
                n.perst_n      = 1'b0;
                n.rst[RB_ACLK] = 1'b1;
                n.rst[RB_PCLK] = 1'b1;
                n.rst[RB_PM]   = 1'b1;
                n.st           = S_ASSERT_CORE;
            end
            S_ASSERT_CORE: begin
                n.rst[RB_CORE]   = 1'b1;
                n.rst[RB_MGMT]   = 1'b1;
                n.rst[RB_STICKY] = 1'b1;
                n.rst[RB_PIPE]   = 1'b1;
                n.phy            = '0;
                n.st             = S_HOLD;
            end
            S_HOLD: if (ms_tick_i && wcnt == LIM_HOLD) n.st = S_REL_BUS;
            S_REL_BUS: begin
                n.rst[RB_PM]   = 1'b0;
                n.rst[RB_ACLK] = 1'b0;
                n.rst[RB_PCLK] = 1'b0;
                n.st           = S_STRAP_SPD;
            end
            S_STRAP_SPD:  n.st = S_STRAP_MODE;
            S_STRAP_MODE: begin
                n.idx = IDX_W'(NPHY - 1);
                n.st  = S_PHY_ON;
            end
            S_PHY_ON: begin
                if ({1'b0, q.idx} < ((IDX_W+1)'(1) << q.lc)) n.phy[q.idx] = 1'b1;
                if (q.idx == '0) n.st = S_REL_CORE;
                else             n.idx = q.idx - 1'b1;
            end
            S_REL_CORE: begin
                case (q.idx)
                    2'd0:    n.rst[RB_STICKY] = 1'b0;
                    2'd1:    n.rst[RB_CORE]   = 1'b0;
                    2'd2:    n.rst[RB_MGMT]   = 1'b0;
                    default: n.rst[RB_PIPE]   = 1'b0;
                endcase
                if (q.idx == 2'd3) n.st = S_PERST_HI;
                else               n.idx = q.idx + 1'b1;
            end
            S_PERST_HI: begin
                n.perst_n = 1'b1;
                n.st      = S_WAIT_PERST;
            end
            S_WAIT_PERST: if (ms_tick_i && wcnt == LIM_PERST) n.st = S_STRAP_TRAIN;
            S_STRAP_TRAIN: n.st = S_POLL_LINK;
            S_POLL_LINK: begin
                if (ms_tick_i && link_st_i == LINK_UP) begin
                    n.st = (q.gen == 2'd2) ? S_RETRAIN : S_SETTLE;
                end else if (ms_tick_i && wcnt == LIM_POLL) begin
                    if (q.gen == 2'd2) begin
                        n.gen = 2'd1;
                        n.st  = S_ASSERT_BUS;
                    end else begin
                        n.fail = 1'b1;
                        n.st   = S_FAIL;
                    end
                end
            end
            S_RETRAIN: n.st = S_POLL_SPD;
            S_POLL_SPD: begin
                if (ms_tick_i && (cur_speed_i & SPD_MASK) == SPD_5GT) begin
                    n.st = S_SETTLE;
                end else if (ms_tick_i && wcnt == LIM_POLL) begin
                    n.gen = 2'd1;
                    n.st  = S_ASSERT_BUS;
                end
            end
            S_SETTLE: begin
                if (ms_tick_i && wcnt == LIM_SETTLE) begin
                    n.done = 1'b1;
                    n.st   = S_DONE;
                end
            end
            default: n.st = S_IDLE;
        endcase
        wclr = (n.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= S_IDLE;
            q.gen     <= '0;
            q.lc      <= '0;
            q.idx     <= '0;
            q.rst     <= '1;
            q.perst_n <= 1'b0;
            q.phy     <= '0;
            q.done    <= 1'b0;
            q.fail    <= 1'b0;
        end else begin
            q <= n;
        end
    end

    rp_tick_counter #(.W(CNT_W)) u_wait_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (wclr),
        .inc_i (ms_tick_i && waiting),
        .cnt_o (wcnt)
    );

    rp_tick_counter #(.W(WAIT_W)) u_waited_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (run_clr),
        .inc_i (ms_tick_i && waiting),
        .cnt_o (waited_ms_o)
    );

    assign strap_kind = (q.st == S_STRAP_SPD)  ? STRAP_SPEED :
                        (q.st == S_STRAP_MODE) ? STRAP_MODE  : STRAP_TRAIN;

    rp_strap_fmt u_strap (
        .kind_i (strap_kind),
        .gen2_i (q.gen == 2'd2),
        .lc_i   (q.lc),
        .word_o (strap_data_o)
    );

    assign strap_wr_o = (q.st == S_STRAP_SPD) || (q.st == S_STRAP_MODE) || (q.st == S_STRAP_TRAIN);
    assign retrain_o  = (q.st == S_RETRAIN);
    assign rst_o      = q.rst;
    assign perst_n_o  = q.perst_n;
    assign phy_en_o   = q.phy;
    assign done_o     = q.done;
    assign fail_o     = q.fail;
    assign gen_o      = q.gen;
endmodule

// File: rtl/rp_bringup_chk.sv
module rp_bringup_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [6:0]   rst_o,
    input logic         perst_n_o,
    input logic         strap_wr_o,
    input logic [31:0]  strap_data_o,
    input logic [3:0]   phy_en_o,
    input logic         retrain_o,
    input logic         done_o,
    input logic         fail_o,
    input logic [1:0]   gen_o,
    input logic [W-1:0] waited_ms_o
);
    p_strap_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strap_wr_o |-> ((strap_data_o[15:0] & ~strap_data_o[31:16]) == 16'h0));

    p_perst_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        perst_n_o |-> (rst_o == 7'h00));

    p_phy_on_bus_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((phy_en_o & ~$past(phy_en_o)) != 4'h0) |-> (rst_o[2:0] == 3'b000 && !perst_n_o));

    p_retrain_gen2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_o |-> (perst_n_o && gen_o == 2'd2));

    p_done_fail_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    p_waited_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || fail_o) && !start_i) |=> $stable(waited_ms_o));
endmodule

bind rp_bringup_seq rp_bringup_chk #(.W(WAIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rst_o        (rst_o),
    .perst_n_o    (perst_n_o),
    .strap_wr_o   (strap_wr_o),
    .strap_data_o (strap_data_o),
    .phy_en_o     (phy_en_o),
    .retrain_o    (retrain_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .gen_o        (gen_o),
    .waited_ms_o  (waited_ms_o)
);

// File: tb/rp_bringup_seq_bench.sv
module rp_bringup_seq_bench;
    localparam int HOLD = 1, PWAIT = 20, POLLS = 500, SETTLE = 80;
    localparam logic [3:0] EV_PERST = 4'd1, EV_RST = 4'd2, EV_PHY = 4'd3,
                           EV_STRAP = 4'd4, EV_RETRAIN = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  max_gen_i = 2'd0;
    logic [2:0]  lanes_i = 3'd1;
    logic        ms_tick_i = 1'b0;
    logic [1:0]  link_st_i;
    logic [7:0]  cur_speed_i;
    logic [6:0]  rst_o;
    logic        perst_n_o, strap_wr_o, retrain_o, done_o, fail_o;
    logic [31:0] strap_data_o;
    logic [3:0]  phy_en_o;
    logic [1:0]  gen_o;
    logic [15:0] waited_ms_o;

    // link partner model
    logic       trained = 1'b0, retrained = 1'b0, cur_g2 = 1'b0;
    logic       ok_g1 = 1'b1, ok_g2 = 1'b1;
    logic [1:0] bad_st = 2'd1;
    logic [7:0] spd_val = 8'hEF;

    assign link_st_i   = !trained ? 2'd0 : ((cur_g2 ? ok_g2 : ok_g1) ? 2'd3 : bad_st);
    assign cur_speed_i = retrained ? spd_val : 8'h00;

    int checks = 0, errors = 0;
    logic [35:0] evq[$];

    always #5 clk = ~clk;

    rp_bringup_seq u_rp_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_gen_i(max_gen_i),
        .lanes_i(lanes_i), .ms_tick_i(ms_tick_i), .link_st_i(link_st_i),
        .cur_speed_i(cur_speed_i), .rst_o(rst_o), .perst_n_o(perst_n_o),
        .strap_wr_o(strap_wr_o), .strap_data_o(strap_data_o), .phy_en_o(phy_en_o),
        .retrain_o(retrain_o), .done_o(done_o), .fail_o(fail_o), .gen_o(gen_o),
        .waited_ms_o(waited_ms_o)
    );

    function automatic string req_of(logic [3:0] k);
        case (k)
            EV_PERST: return "R6";
            EV_RST:   return "R3";
            EV_PHY:   return "R5";
            EV_STRAP: return "R2";
            default:  return "R8";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(logic [3:0] k, logic [31:0] v);
        evq.push_back({k, v});
    endtask

    // monitor: compare each observed output event against the queue front
    task automatic seen(logic [3:0] k, logic [31:0] v);
        logic [35:0] e;
        checks++;
        if (evq.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected event kind %0d actual %h expected none", req_of(k), k, v);
        end else begin
            e = evq.pop_front();
            if (e !== {k, v}) begin
                errors++;
                $display("FAIL %s: event actual %0d/%h expected %0d/%h",
                         req_of(k), k, v, e[35:32], e[31:0]);
            end
        end
    endtask

    logic       prev_perst = 1'b0;
    logic [6:0] prev_rst = 7'h7F;
    logic [3:0] prev_phy = 4'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (perst_n_o !== prev_perst) begin
                seen(EV_PERST, {31'd0, perst_n_o});
                if (!perst_n_o) begin trained = 1'b0; retrained = 1'b0; end
                prev_perst = perst_n_o;
            end
            if (rst_o !== prev_rst) begin
                seen(EV_RST, {25'd0, rst_o});
                prev_rst = rst_o;
            end
            if (phy_en_o !== prev_phy) begin
                seen(EV_PHY, {28'd0, phy_en_o});
                prev_phy = phy_en_o;
            end
            if (strap_wr_o) begin
                seen(EV_STRAP, strap_data_o);
                if (strap_data_o[23]) cur_g2 = strap_data_o[7];
                if (strap_data_o[17] && strap_data_o[1]) trained = 1'b1;
            end
            if (retrain_o) begin
                seen(EV_RETRAIN, 32'd0);
                retrained = 1'b1;
            end
        end
    end

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ms_tick_i = 1'b1;
            @(negedge clk);
            ms_tick_i = 1'b0;
        end
    end

    // driver: expected events of one attempt (R2..R6, R8)
    task automatic push_attempt(bit g2, logic [1:0] lc, bit released, bit do_retrain);
        logic [3:0] v;
        if (released) begin
            push(EV_PERST, 32'd0);            // R3 PERST low with bus group
            push(EV_RST, 32'h07);
            push(EV_RST, 32'h7F);             // R3 core group next cycle
            push(EV_PHY, 32'h0);
        end
        push(EV_RST, 32'h78);                 // R4 bus group released together
        push(EV_STRAP, g2 ? 32'h00800080 : 32'h00800000);
        push(EV_STRAP, 32'h00710041 | (32'(lc) << 4));
        v = 4'h0;
        for (int i = 3; i >= 0; i--) begin    // R5 lanes walk down
            if (i < (1 << lc)) begin
                v[i] = 1'b1;
                push(EV_PHY, {28'd0, v});
            end
        end
        push(EV_RST, 32'h58);                 // R6 sticky, core, mgmt, pipe
        push(EV_RST, 32'h50);
        push(EV_RST, 32'h40);
        push(EV_RST, 32'h00);
        push(EV_PERST, 32'd1);
        push(EV_STRAP, 32'h00020002);
        if (do_retrain) push(EV_RETRAIN, 32'd0);
    endtask

    task automatic run(logic [1:0] mg, logic [2:0] ln, bit mid_start);
        @(negedge clk);
        max_gen_i = mg;
        lanes_i   = ln;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            while (!perst_n_o) @(negedge clk);
            repeat (7) @(negedge clk);
            start_i = 1'b1;                   // R11 must be ignored
            max_gen_i = 2'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!(done_o || fail_o)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run(string tag, bit exp_done, logic [1:0] exp_gen, int exp_ms);
        chk({tag, " R9 done"}, {31'd0, done_o}, {31'd0, exp_done});
        chk({tag, " R7 fail"}, {31'd0, fail_o}, {31'd0, !exp_done});
        chk({tag, " R10 gen"}, {30'd0, gen_o}, {30'd0, exp_gen});
        chk({tag, " R12 waited"}, {16'd0, waited_ms_o}, 32'(exp_ms));
        chk({tag, " R2 queue drained"}, evq.size(), 0);
        evq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 rst", {25'd0, rst_o}, 32'h7F);
        chk("R1 perst", {31'd0, perst_n_o}, 0);
        chk("R1 phy", {28'd0, phy_en_o}, 0);
        chk("R1 flags", {28'd0, strap_wr_o, retrain_o, done_o, fail_o}, 0);
        chk("R1 gen", {30'd0, gen_o}, 0);
        chk("R1 waited", {16'd0, waited_ms_o}, 0);
        rst_n = 1'b1;

        // default Gen1, one lane (R10 value 0)
        ok_g1 = 1; ok_g2 = 1; spd_val = 8'hEF;
        push_attempt(0, 2'd0, 0, 0);
        run(2'd0, 3'd1, 0);
        finish_run("gen1x1", 1, 2'd1, HOLD + PWAIT + 1 + SETTLE);

        // Gen2, four lanes, speed bits beyond mask ignored (R8)
        push_attempt(1, 2'd2, 1, 1);
        run(2'd3, 3'd4, 0);
        finish_run("gen2x4", 1, 2'd2, HOLD + PWAIT + 1 + 1 + SETTLE);

        // Gen2 link never comes up, fallback to Gen1 (R7)
        ok_g2 = 0; bad_st = 2'd1;
        push_attempt(1, 2'd1, 1, 0);
        push_attempt(0, 2'd1, 1, 0);
        run(2'd2, 3'd2, 0);
        finish_run("fallback_link", 1, 2'd1, (HOLD + PWAIT + POLLS) + (HOLD + PWAIT + 1 + SETTLE));

        // Gen2 link up but speed stays wrong (R8)
        ok_g2 = 1; spd_val = 8'h18;
        push_attempt(1, 2'd0, 1, 1);
        push_attempt(0, 2'd0, 1, 0);
        run(2'd2, 3'd1, 0);
        finish_run("fallback_speed", 1, 2'd1, (HOLD + PWAIT + 1 + POLLS) + (HOLD + PWAIT + 1 + SETTLE));

        // Gen1 stuck in DL init: state 2 is not success (R7)
        ok_g1 = 0; bad_st = 2'd2;
        push_attempt(0, 2'd1, 1, 0);
        run(2'd1, 3'd2, 0);
        finish_run("gen1_fail", 0, 2'd1, HOLD + PWAIT + POLLS);

        // start from fail accepted, busy start ignored (R11)
        ok_g1 = 1;
        push_attempt(0, 2'd0, 1, 0);
        run(2'd0, 3'd1, 1);
        finish_run("busy_start_R11", 1, 2'd1, HOLD + PWAIT + 1 + SETTLE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule